// File: doc/BRIEF.md
# Byte-Addressed Seconds Counter Real-Time Clock

This block keeps wall-clock time as a 32-bit binary count of seconds. An external one-pulse-per-second strobe advances the count while a run bit in the control register is set. Software reaches the count over a narrow byte-wide register bus with an address, a write strobe, write data and combinational read data. The count is split into four byte registers for loading and four byte registers for reading back. A fixed identification register lets software recognise the peripheral. The full 32-bit count also leaves the block on a dedicated output so that an alarm comparator can watch it.

The count may keep running while it is loaded or read, so a carry out of the low byte can reach the upper bytes at any moment. Software gets a coherent load by clearing the low byte first, writing the three upper bytes and writing the low byte last. It gets a coherent read by reading the low byte again at the end and re-reading all four bytes if that second value is smaller than the first.

Top module: `sec_rtc`

## Requirements
- R1: After synchronous reset the count is 0, the run bit is 0 (control reads 0x00), and any offset not mapped below reads 0x00.
- R2: Offsets 0x48, 0x49, 0x4A and 0x4B return bytes 0 (least significant) to 3 of the live count, combinationally in the same cycle as the address.
- R3: A write to offset 0x40+k (k = 0..3) replaces byte k of the count on that clock edge and leaves the other three bytes unchanged.
- R4: Control register offset 0x46 holds the run bit at bit 7 (reads 0x80 when set, 0x00 when clear); while it is clear, tick pulses leave the count unchanged.
- R5: Each cycle in which the tick is high and the run bit is set adds one to the count, carrying across byte boundaries; 0xFFFFFFFF advances to 0x00000000.
- R6: When a byte write and a tick fall in the same cycle, the write is applied first and the result is then incremented.
- R7: The identification register at offset 0x05 always reads 0x01.
- R8: Writes to the read-back offsets 0x48 to 0x4B, to the identification register and to unmapped offsets are ignored; the load offsets 0x40 to 0x43 read 0x00.
- R9: With the count running, the sequence clear byte 0, write bytes 1 to 3, write byte 0 yields exactly the intended value plus the ticks seen since the final write.
- R10: Reading byte 0 before and after a rollover of byte 0 shows a smaller second value, and byte 1 then reads one higher.
- R11: The 32-bit time output always equals the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_pps | input | 1 | One-cycle pulse per second |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| time_out | output | 32 | Live seconds count for the alarm unit |

## Verification
A byte load and a running tick can hit the same clock edge, and the design must apply the load first and the increment on top of it. The bench provokes this by raising the tick in the very cycle of a write to byte 2 and of a write to byte 0, then reads the written byte and the low byte back and expects the loaded value with one added. The same overlap is exercised over a whole four-write coherent load with a tick on every write, judged against the intended value plus one.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFF_SUBTYPE = 8'h05;
    localparam logic [ADDR_W-1:0] OFF_LOAD    = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h46;
    localparam logic [ADDR_W-1:0] OFF_READ    = 8'h48;

    localparam logic [DATA_W-1:0] SUBTYPE_VAL = 8'h01;
    localparam int RUN_BIT = 7;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_ID,
        RSEL_COUNT
    } rsel_e;

    function automatic logic [DATA_W-1:0] ctrl_image(input logic run);
        logic [DATA_W-1:0] v;
        v = '0;
        v[RUN_BIT] = run;
        return v;
    endfunction

endpackage

// File: rtl/sec_rtc_addr_dec.sv
module sec_rtc_addr_dec
    import sec_rtc_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NBYTES-1:0] byte_we,
    output logic              ctrl_we,
    output rsel_e             rsel,
    output logic [IDX_W-1:0]  ridx
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_we
        assign byte_we[b] = wr && (addr == OFF_LOAD + ADDR_W'(b));
    end

    assign ctrl_we = wr && (addr == OFF_CTRL);

    always_comb begin
        rsel = RSEL_NONE;
        ridx = '0;
        if (addr == OFF_CTRL)    rsel = RSEL_CTRL;
        if (addr == OFF_SUBTYPE) rsel = RSEL_ID;
        for (int b = 0; b < NBYTES; b++) begin
            if (addr == OFF_READ + ADDR_W'(b)) begin
                rsel = RSEL_COUNT;
                ridx = IDX_W'(b);
            end
        end
    end

endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter
    import sec_rtc_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int CNT_W = NBYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NBYTES-1:0] byte_we,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              run
);

    logic [CNT_W-1:0] loaded;

    for (genvar b = 0; b < NBYTES; b++) begin : g_load
        assign loaded[b*DATA_W +: DATA_W] =
            byte_we[b] ? wdata : count[b*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run   <= 1'b0;
        end else begin
            count <= loaded + CNT_W'(tick && run);
            if (ctrl_we) run <= wdata[RUN_BIT];
        end
    end

endmodule

// File: rtl/sec_rtc_rdmux.sv
module sec_rtc_rdmux
    import sec_rtc_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int CNT_W = NBYTES * DATA_W
) (
    input  rsel_e             rsel,
    input  logic [IDX_W-1:0]  ridx,
    input  logic [CNT_W-1:0]  count,
    input  logic              run,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (rsel)
            RSEL_CTRL:  rdata = ctrl_image(run);
            RSEL_ID:    rdata = SUBTYPE_VAL;
            RSEL_COUNT: rdata = count[ridx*DATA_W +: DATA_W];
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int CNT_W = NBYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_pps,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  time_out
);

    logic [NBYTES-1:0] byte_we;
    logic              ctrl_we;
    rsel_e             rsel;
    logic [IDX_W-1:0]  ridx;
    logic              run_en;

    sec_rtc_addr_dec #(.NBYTES(NBYTES)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .byte_we (byte_we),
        .ctrl_we (ctrl_we),
        .rsel    (rsel),
        .ridx    (ridx)
    );

    sec_rtc_counter #(.NBYTES(NBYTES)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_pps),
        .byte_we (byte_we),
        .ctrl_we (ctrl_we),
        .wdata   (bus_wdata),
        .count   (time_out),
        .run     (run_en)
    );

    sec_rtc_rdmux #(.NBYTES(NBYTES)) u_mux (
        .rsel  (rsel),
        .ridx  (ridx),
        .count (time_out),
        .run   (run_en),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker
    import sec_rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_pps,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [31:0]       time_out,
    input logic              run_en
);

    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst) |-> time_out == 32'h0);

    p_live_top_r2: assert property (@(posedge clk) disable iff (rst)
        bus_addr == OFF_READ + 8'd3 |-> bus_rdata == time_out[31:24]);

    p_byte1_load_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_LOAD + 8'd1 && !tick_pps)
        |=> time_out[15:8] == $past(bus_wdata));

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !bus_wr) |=> $stable(time_out));

    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick_pps && !bus_wr) |=> time_out == $past(time_out) + 32'd1);

    p_ident_r7: assert property (@(posedge clk) disable iff (rst)
        bus_addr == OFF_SUBTYPE |-> bus_rdata == SUBTYPE_VAL);

endmodule

bind sec_rtc sec_rtc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_pps  (tick_pps),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .time_out  (time_out),
    .run_en    (run_en)
);

// File: tb/sec_rtc_bench.sv
`timescale 1ns/1ps
module sec_rtc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_pps = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [31:0] time_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sec_rtc u_sec_rtc (
        .clk       (clk),
        .rst       (rst),
        .tick_pps  (tick_pps),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .time_out  (time_out)
    );

    // {wr, addr, wdata, tick, read addr, expected read}
    localparam int NVEC = 16;
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b1, 8'h41, 8'h12, 1'b0, 8'h49, 8'h12},
        {1'b1, 8'h48, 8'h55, 1'b0, 8'h48, 8'h00},
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h48, 8'h00},
        {1'b1, 8'h46, 8'h80, 1'b0, 8'h46, 8'h80},
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h48, 8'h01},
        {1'b1, 8'h40, 8'hFF, 1'b0, 8'h48, 8'hFF},
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h48, 8'h00},
        {1'b0, 8'h00, 8'h00, 1'b0, 8'h49, 8'h13},
        {1'b1, 8'h42, 8'hAB, 1'b1, 8'h4A, 8'hAB},
        {1'b0, 8'h00, 8'h00, 1'b0, 8'h48, 8'h01},
        {1'b1, 8'h40, 8'h10, 1'b1, 8'h48, 8'h11},
        {1'b0, 8'h00, 8'h00, 1'b0, 8'h40, 8'h00},
        {1'b0, 8'h00, 8'h00, 1'b0, 8'h05, 8'h01},
        {1'b1, 8'h05, 8'h77, 1'b0, 8'h05, 8'h01},
        {1'b1, 8'h4C, 8'h66, 1'b0, 8'h4C, 8'h00},
        {1'b1, 8'h46, 8'h00, 1'b0, 8'h46, 8'h00}
    };
    localparam string TAG [NVEC] = '{
        "R3", "R8", "R4", "R4", "R5", "R3", "R5", "R5",
        "R6", "R6", "R6", "R8", "R7", "R8", "R1", "R4"
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle; returns at the falling edge after the rising edge
    task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d, input logic t);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_pps = t;
        @(negedge clk);
        bus_wr = 1'b0; tick_pps = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, first0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h46, v); check("R1 ctrl", {24'h0, v}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            rd(8'h48 + 8'(k), v); check("R1 count byte", {24'h0, v}, 32'h0);
        end
        rd(8'h00, v); check("R1 unmapped", {24'h0, v}, 32'h0);
        check("R11 reset", time_out, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][33], VEC[i][32:25], VEC[i][24:17], VEC[i][16]);
            rd(VEC[i][15:8], v);
            check(TAG[i], {24'h0, v}, {24'h0, VEC[i][7:0]});
        end
        check("R11 after table", time_out, 32'h00AB1311);

        // R5 full wrap
        step(1'b1, 8'h46, 8'h80, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 8'h40 + 8'(k), 8'hFF, 1'b0);
        check("R11 all ones", time_out, 32'hFFFFFFFF);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        check("R5 wrap", time_out, 32'h0);

        // R9 coherent load while running, tick on every write
        step(1'b1, 8'h40, 8'hFE, 1'b0);
        step(1'b1, 8'h40, 8'h00, 1'b1);
        step(1'b1, 8'h41, 8'h34, 1'b1);
        step(1'b1, 8'h42, 8'h56, 1'b1);
        step(1'b1, 8'h43, 8'h78, 1'b1);
        step(1'b1, 8'h40, 8'h9A, 1'b1);
        check("R9 coherent load", time_out, 32'h7856349B);

        // R10 rollover between reads
        step(1'b1, 8'h40, 8'hFF, 1'b0);
        rd(8'h48, first0);
        rd(8'h49, v); check("R10 byte1 before", {24'h0, v}, 32'h34);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        rd(8'h48, v);
        check("R10 smaller second read", {31'h0, v < first0}, 32'h1);
        rd(8'h49, v); check("R10 byte1 after", {24'h0, v}, 32'h35);
        rd(8'h4B, v); check("R2 top byte", {24'h0, v}, 32'h78);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule